// File: doc/BRIEF.md
# Output Denormalize and Clamp Stage

This stage sits after a color matrix and turns each normalized fixed-point component into an integer code at the selected output depth. The input components are unsigned. They carry 12 fractional bits, so an input of 4096 stands for 1.0. For an output depth of n bits, the stage multiplies the normalized value by 2^n − 1, rounds to the nearest integer and clamps the result to the range 0 to 2^n − 1. This is the same as scaling the value, taken as a fraction of 2^n, by (2^n − 1)/2^n. A depth code of zero skips the scaling and passes the fraction bits through, truncated.

One control register holds the depth code and a narrow-bus flag. When the flag is set, every result is placed on a 10-bit field, whatever the depth. Pixels move as a three-component stream with a valid/ready handshake through a two-register pipeline. The whole pipeline advances only when the downstream side is ready. Each pixel keeps the control settings that were in force on the cycle it was accepted.

Top module: `dnc_denorm_clamp`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 (depth code 0, flag clear) and `out_valid` is low.
- R2: A write with `cfg_we` high stores the depth code in bits [1:0] and the narrow-bus flag in bit 2. All other bits of `cfg_rdata` read as zero.
- R3: With depth code 1 (8-bit), each output is round(x·255/4096), clamped to 255, where x is the raw input.
- R4: With depth code 2 (10-bit), each output is round(x·1023/4096), clamped to 1023.
- R5: With depth code 3 (12-bit), each output is round(x·4095/4096), clamped to 4095.
- R6: Inputs at or above 1.0 (x ≥ 4096) produce the full-scale code of the selected depth. No output exceeds 2^n − 1 while the flag is clear.
- R7: With the flag set, 8-bit results are shifted left by 2, 10-bit results are unchanged, and 12-bit results are shifted right by 2 (rounded down). Output bits above bit 9 are zero.
- R8: With depth code 0, the output is the input's 12 fraction bits x[11:0]. With the flag also set, the output is x[11:2].
- R9: A pixel accepted at clock edge k appears on `out_valid`/`out_data` after edge k+1, provided `out_ready` stays high. The pixel uses the control value held before edge k, and later writes do not change it.
- R10: `in_ready` follows `out_ready`. While `out_ready` is low the pipeline holds: a presented output stays valid and unchanged, and no new pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data: bits [1:0] depth code, bit 2 narrow-bus flag |
| cfg_rdata | output | 8 | Current control register value |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept an input pixel |
| in_data | input | 48 | Three 16-bit components, component 0 in bits [15:0] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 36 | Three 12-bit codes, component 0 in bits [11:0] |

## Verification
The latency property assumes the downstream side holds `out_ready` high for the two cycles it relates. The hold property assumes that a stalled output is only released by `out_ready`. The bench therefore changes `out_ready` only at falling edges and never drops it during a latency measurement. The clamp and narrow-field properties read the control snapshot that travels with each pixel, so they stay valid when the control register is rewritten while pixels are in flight. The bench does exactly that in its snapshot scenario. Inputs are driven only at falling edges, and the control register is written only by single-cycle strobes.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

    localparam int MAX_DEPTH  = 12;
    localparam int NARROW_W   = 10;
    localparam int FLAG_BIT   = 2;
    localparam int CTRL_USED  = 3;

    typedef enum logic [1:0] {
        DEPTH_RAW = 2'd0,
        DEPTH_8   = 2'd1,
        DEPTH_10  = 2'd2,
        DEPTH_12  = 2'd3
    } depth_e;

    typedef struct packed {
        logic   v1;
        depth_e m1;
        logic   f1;
        logic   v2;
        depth_e m2;
        logic   f2;
    } pipe_t;

    // Largest code of a depth; also the scale multiplier (2^n - 1).
    function automatic logic [MAX_DEPTH-1:0] code_max(depth_e m);
        case (m)
            DEPTH_8:  code_max = 12'd255;
            DEPTH_10: code_max = 12'd1023;
            DEPTH_12: code_max = 12'd4095;
            default:  code_max = '0;
        endcase
    endfunction

endpackage

// File: rtl/dnc_ctrl_reg.sv
module dnc_ctrl_reg
    import dnc_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output depth_e           mode,
    output logic             narrow
);
    localparam logic [CFG_W-1:0] KEEP_MASK = CFG_W'((1 << CTRL_USED) - 1);

    logic [CFG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata  = reg_q;
    assign mode   = depth_e'(reg_q[1:0]);
    assign narrow = reg_q[FLAG_BIT];

endmodule

// File: rtl/dnc_lane.sv
module dnc_lane
    import dnc_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 12,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [IN_W-1:0]   pix_i,
    input  depth_e            mode_in,
    input  depth_e            mode_s1,
    input  logic              flag_s1,
    output logic [OUT_W-1:0]  pix_o
);
    localparam int PROD_W = IN_W + MAX_DEPTH;
    localparam int RND_W  = PROD_W - FRAC_W + 1;
    localparam logic [PROD_W:0] HALF = (PROD_W+1)'(1) << (FRAC_W - 1);

    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic [FRAC_W-1:0] frac;
        logic [OUT_W-1:0]  res;
    } lane_t;

    lane_t st_d, st_q;

    logic [PROD_W:0]   biased;
    logic [RND_W-1:0]  rnd;
    logic [RND_W-1:0]  lim;
    logic [RND_W-1:0]  clamped;
    logic [OUT_W-1:0]  fmt_v;

    always_comb begin
        // stage 2 arithmetic on the registered product
        biased  = {1'b0, st_q.prod} + HALF;
        rnd     = RND_W'(biased >> FRAC_W);
        lim     = RND_W'(code_max(mode_s1));
        clamped = (rnd > lim) ? lim : rnd;

        case (mode_s1)
            DEPTH_RAW: fmt_v = flag_s1 ? OUT_W'(st_q.frac >> (FRAC_W - NARROW_W))
                                       : OUT_W'(st_q.frac >> (FRAC_W - OUT_W));
            DEPTH_8:   fmt_v = flag_s1 ? OUT_W'(clamped << 2) : OUT_W'(clamped);
            DEPTH_10:  fmt_v = OUT_W'(clamped);
            default:   fmt_v = flag_s1 ? OUT_W'(clamped >> 2) : OUT_W'(clamped);
        endcase

        st_d = st_q;
        if (adv) begin
            st_d.prod = PROD_W'(pix_i) * PROD_W'(code_max(mode_in));
            st_d.frac = pix_i[FRAC_W-1:0];
            st_d.res  = fmt_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o = st_q.res;

endmodule

// File: rtl/dnc_denorm_clamp.sv
module dnc_denorm_clamp
    import dnc_pkg::*;
#(
    parameter int NCOMP  = 3,
    parameter int IN_W   = 16,
    parameter int FRAC_W = 12,
    parameter int OUT_W  = 12,
    parameter int CFG_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [CFG_W-1:0]        cfg_rdata,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NCOMP*IN_W-1:0]   in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [NCOMP*OUT_W-1:0]  out_data
);
    depth_e cur_mode;
    logic   cur_narrow;
    pipe_t  pp_d, pp_q;
    logic   adv;
    depth_e tag_mode_q;
    logic   tag_flag_q;

    dnc_ctrl_reg #(.CFG_W(CFG_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .mode   (cur_mode),
        .narrow (cur_narrow)
    );

    assign adv = out_ready;

    always_comb begin
        pp_d = pp_q;
        if (adv) begin
            pp_d.v1 = in_valid;
            pp_d.m1 = cur_mode;
            pp_d.f1 = cur_narrow;
            pp_d.v2 = pp_q.v1;
            pp_d.m2 = pp_q.m1;
            pp_d.f2 = pp_q.f1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    generate
        for (genvar gi = 0; gi < NCOMP; gi++) begin : g_lane
            dnc_lane #(
                .IN_W   (IN_W),
                .FRAC_W (FRAC_W),
                .OUT_W  (OUT_W)
            ) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv),
                .pix_i   (in_data[gi*IN_W +: IN_W]),
                .mode_in (cur_mode),
                .mode_s1 (pp_q.m1),
                .flag_s1 (pp_q.f1),
                .pix_o   (out_data[gi*OUT_W +: OUT_W])
            );
        end
    endgenerate

    assign in_ready   = out_ready;
    assign out_valid  = pp_q.v2;
    assign tag_mode_q = pp_q.m2;
    assign tag_flag_q = pp_q.f2;

endmodule

// File: rtl/dnc_checker.sv
module dnc_checker
    import dnc_pkg::*;
#(
    parameter int NCOMP = 3,
    parameter int OUT_W = 12,
    parameter int CFG_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CFG_W-4:0]       cfg_hi,
    input logic                   in_valid,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [NCOMP*OUT_W-1:0] out_data,
    input depth_e                 tag_mode,
    input logic                   tag_flag
);
    logic [1:0] age;
    logic       over_lim;
    logic       wide_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    always_comb begin
        over_lim = 1'b0;
        wide_hi  = 1'b0;
        for (int i = 0; i < NCOMP; i++) begin
            if (out_data[i*OUT_W +: OUT_W] > OUT_W'(code_max(tag_mode))) over_lim = 1'b1;
            if ((out_data[i*OUT_W +: OUT_W] >> NARROW_W) != '0) wide_hi = 1'b1;
        end
    end

    assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hi == '0);

    assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !tag_flag && tag_mode != DEPTH_RAW) |-> !over_lim);

    assert_narrow_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tag_flag) |-> !wide_hi);

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(out_ready, 1) && $past(out_ready, 2))
            |-> (out_valid == $past(in_valid, 2)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind dnc_denorm_clamp dnc_checker #(
    .NCOMP (NCOMP),
    .OUT_W (OUT_W),
    .CFG_W (CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_hi    (cfg_rdata[CFG_W-1:3]),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .tag_mode  (tag_mode_q),
    .tag_flag  (tag_flag_q)
);

// File: tb/sim_dnc_denorm_clamp.sv
module sim_dnc_denorm_clamp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        in_valid;
    logic        in_ready;
    logic [47:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [35:0] out_data;

    int errors = 0;
    int checks = 0;
    int cur_mode = 0;
    int cur_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dnc_denorm_clamp u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(int x, int mode, int flag);
        longint mx, r;
        int n;
        if (mode == 0) begin
            r = x & 4095;
            return flag ? int'(r >> 2) : int'(r);
        end
        n  = (mode == 1) ? 8 : (mode == 2) ? 10 : 12;
        mx = (longint'(1) << n) - 1;
        r  = (longint'(x) * mx + 2048) >> 12;
        if (r > mx) r = mx;
        if (flag != 0 && n == 8)  r = r << 2;
        if (flag != 0 && n == 12) r = r >> 2;
        return int'(r);
    endfunction

    task automatic write_cfg(int mode, int flag);
        cfg_wdata = 8'hF8 | 8'(mode) | (flag != 0 ? 8'h04 : 8'h00);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_mode = mode;
        cur_flag = flag;
    endtask

    task automatic push(int a, int b, int c);
        in_data  = {16'(c), 16'(b), 16'(a)};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_out(string req, int a, int b, int c, int mode, int flag);
        chk({req, " valid"}, out_valid, 1);
        chk({req, " c0"}, out_data[11:0],  exp_code(a, mode, flag));
        chk({req, " c1"}, out_data[23:12], exp_code(b, mode, flag));
        chk({req, " c2"}, out_data[35:24], exp_code(c, mode, flag));
    endtask

    task automatic pix(string req, int a, int b, int c);
        push(a, b, c);
        @(negedge clk);
        check_out(req, a, b, c, cur_mode, cur_flag);
    endtask

    task automatic t_reset_R1;
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 out_valid", out_valid, 0);
    endtask

    task automatic t_cfg_R2;
        write_cfg(3, 1);
        chk("R2 readback full", cfg_rdata, 8'h07);
        write_cfg(1, 0);
        chk("R2 readback mode1", cfg_rdata, 8'h01);
        write_cfg(2, 1);
        chk("R2 readback flag", cfg_rdata, 8'h06);
    endtask

    task automatic t_depths_R3_R4_R5;
        write_cfg(1, 0);
        pix("R3 8-bit", 4096, 2048, 0);
        pix("R3 8-bit odd", 1000, 3, 4095);
        write_cfg(2, 0);
        pix("R4 10-bit", 4096, 2048, 1000);
        pix("R4 10-bit small", 1, 2, 777);
        write_cfg(3, 0);
        pix("R5 12-bit", 4096, 2048, 1000);
        pix("R5 12-bit small", 1, 3, 4095);
    endtask

    task automatic t_clamp_R6;
        write_cfg(1, 0);
        pix("R6 clamp 8", 8192, 65535, 4097);
        chk("R6 full scale 8", out_data[11:0], 255);
        write_cfg(2, 0);
        pix("R6 clamp 10", 65535, 4096, 5000);
        write_cfg(3, 0);
        pix("R6 clamp 12", 65535, 12288, 4096);
        chk("R6 full scale 12", out_data[23:12], 4095);
    endtask

    task automatic t_narrow_R7;
        write_cfg(1, 1);
        pix("R7 narrow 8", 2048, 4096, 1000);
        chk("R7 8 shift", out_data[11:0], 512);
        write_cfg(2, 1);
        pix("R7 narrow 10", 2048, 4096, 1000);
        write_cfg(3, 1);
        pix("R7 narrow 12", 2048, 65535, 1001);
        chk("R7 12 shift", out_data[23:12], 1023);
    endtask

    task automatic t_bypass_R8;
        write_cfg(0, 0);
        pix("R8 bypass", 16'h1ABC, 16'hFFFF, 16'h0003);
        chk("R8 truncate", out_data[11:0], 12'hABC);
        write_cfg(0, 1);
        pix("R8 bypass narrow", 16'h1ABC, 16'hFFFF, 16'h0003);
        chk("R8 narrow value", out_data[11:0], 12'h2AF);
    endtask

    task automatic t_snapshot_R9;
        write_cfg(3, 0);
        // write and pixel on the same edge: pixel takes the old setting
        cfg_wdata = 8'h01;
        cfg_we    = 1'b1;
        in_data   = {16'd1000, 16'd4096, 16'd2048};
        in_valid  = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
        in_valid  = 1'b0;
        chk("R9 not yet valid", out_valid, 0);
        @(negedge clk);
        check_out("R9 old setting", 2048, 4096, 1000, 3, 0);
        @(negedge clk);
        chk("R9 single beat", out_valid, 0);
        cur_mode = 1;
        cur_flag = 0;
        // pixel in flight while the register changes
        push(2048, 4096, 1000);
        write_cfg(2, 1);
        check_out("R9 in flight", 2048, 4096, 1000, 1, 0);
    endtask

    task automatic t_stall_R10;
        write_cfg(2, 0);
        push(2048, 1000, 4096);
        out_ready = 1'b0;
        #1;
        chk("R10 in_ready low", in_ready, 0);
        repeat (3) @(negedge clk);
        chk("R10 held bubble", out_valid, 0);
        out_ready = 1'b1;
        @(negedge clk);
        check_out("R10 released", 2048, 1000, 4096, 2, 0);
        @(negedge clk);
        push(100, 200, 300);
        @(negedge clk);
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R10 stalled output", 100, 200, 300, 2, 0);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R10 drained", out_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0;
        cfg_wdata = '0;
        in_valid = 1'b0;
        in_data = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_cfg_R2();
        t_depths_R3_R4_R5();
        t_clamp_R6();
        t_narrow_R7();
        t_bypass_R8();
        t_snapshot_R9();
        t_stall_R10();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule